// File: doc/BRIEF.md
# Raster Timing Generator with Video Status Word

This block produces the horizontal and vertical timing of one raster display from a pixel-clock enable. Two identical segment sequencers, one per axis, walk through the visible, front-porch, sync and back-porch segments. From those segments the block derives active-high sync and blanking outputs. It also raises a vertical interrupt that is held as a level. The same level is driven onto two interrupt outputs so that two processors see it at once.

A processor reads a 16-bit status word through a one-strobe read port. The upper byte carries the sync and blanking flags as active-low bits, and every other bit of that byte reads 1. The lower byte carries the current line moved 15 lines ahead, wrapped at the frame height, and clamped to 0xFF when the result does not fit in a byte. The word is taken in the cycle of the strobe and returned one cycle later, so the fields inside one word always belong to the same instant.

The horizontal sequencer has these segments: SEG_VISIBLE (columns 0 to 319), SEG_FRONT (320 to 335), SEG_SYNC (336 to 367) and SEG_BACK (368 to 431). Each one advances to the next when the last column of the segment is stepped. The vertical sequencer uses the same segments for lines 0 to 239, 240 to 244, 245 to 247 and 248 to 261, and it is stepped once per line wrap.

The read port has two states. It moves from RD_IDLE to RD_REPLY on a strobe, and it returns to RD_IDLE when there is no strobe. The interrupt controller also has two states. It moves from IRQ_IDLE to IRQ_RAISED when the last visible line ends, and it moves from IRQ_RAISED back to IRQ_IDLE on an acknowledge.

Top module: `scan_timing_status`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets both counters to 0, both interrupt outputs to 0, status_valid to 0 and status_data to 0x0000.
- R2: hcount increments only on edges where pix_en is 1 and wraps from 431 to 0. vcount increments only on the edge where hcount wraps, and it wraps from 261 to 0.
- R3: hsync is 1 exactly while hcount is in 336..367. vsync is 1 exactly while vcount is in 245..247.
- R4: blank is 1 exactly when hcount >= 320 or vcount >= 240.
- R5: The status word has bit 15 = not hsync, bit 14 = not vsync, bit 8 = not blank, and bits 13..9 = 1. When no signal is active, the upper byte reads 0xFF.
- R6: Status bits 7..0 hold L = (vcount + 15) mod 262 when L < 256, and 0xFF otherwise.
- R7: When rd_stb is 1 at an edge, the word built from the values present in that cycle appears on status_data in the next cycle, with status_valid set to 1 for exactly that cycle. status_data holds its value until the next strobe.
- R8: vint_main and vint_sub are always equal. They rise in the first cycle in which vcount is 240 (hcount 0), and they then stay high as a level.
- R9: When irq_ack is 1 at an edge, the interrupt is clear in the next cycle, unless the same edge raises it, in which case raising wins. An acknowledge while the interrupt is already low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-clock enable, one column per asserted cycle |
| rd_stb | input | 1 | Status read strobe |
| irq_ack | input | 1 | Vertical interrupt acknowledge pulse |
| hcount | output | 9 | Current column |
| vcount | output | 9 | Current line |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Combined blanking, active high |
| status_data | output | 16 | Captured status word |
| status_valid | output | 1 | One-cycle flag marking a fresh status word |
| vint_main | output | 1 | Vertical interrupt level, first processor |
| vint_sub | output | 1 | Vertical interrupt level, second processor |

## Verification
The counters, sync and blank outputs are due in the cycle after the edge that steps them. The status word and its valid flag are due one cycle after the strobe, and they reflect the counters as they stood in the strobe cycle. The interrupt is due in the cycle after the edge that ends line 239, and its clearing is due in the cycle after an acknowledge. The bench keeps a cycle model that advances on the same edges. It compares every output at the falling edge, before it drives the next inputs. This places each comparison exactly one register stage after its cause.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;
    typedef enum logic [1:0] {
        SEG_VISIBLE = 2'd0,
        SEG_FRONT   = 2'd1,
        SEG_SYNC    = 2'd2,
        SEG_BACK    = 2'd3
    } seg_t;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_REPLY = 1'b1
    } rd_state_t;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/raster_axis.sv
module raster_axis
    import scan_timing_pkg::*;
#(
    parameter int TOTAL      = 432,
    parameter int ACTIVE     = 320,
    parameter int SYNC_START = 336,
    parameter int SYNC_LEN   = 32,
    localparam int CW        = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [CW-1:0] count,
    output seg_t          seg,
    output logic          wrap,
    output logic          leave_visible
);
    localparam logic [CW-1:0] VIS_LAST   = CW'(ACTIVE - 1);
    localparam logic [CW-1:0] FRONT_LAST = CW'(SYNC_START - 1);
    localparam logic [CW-1:0] SYNC_LAST  = CW'(SYNC_START + SYNC_LEN - 1);
    localparam logic [CW-1:0] LAST       = CW'(TOTAL - 1);

    seg_t          seg_next;
    logic [CW-1:0] count_next;

    // segment sequencing: leave a segment on its last position
    always_comb begin
        seg_next = seg;
        if (step) begin
            unique case (seg)
                SEG_VISIBLE: if (count == VIS_LAST)   seg_next = SEG_FRONT;
                SEG_FRONT:   if (count == FRONT_LAST) seg_next = SEG_SYNC;
                SEG_SYNC:    if (count == SYNC_LAST)  seg_next = SEG_BACK;
                SEG_BACK:    if (count == LAST)       seg_next = SEG_VISIBLE;
            endcase
        end
    end

    always_comb begin
        count_next = count;
        if (step) count_next = (count == LAST) ? '0 : count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg   <= SEG_VISIBLE;
            count <= '0;
        end else begin
            seg   <= seg_next;
            count <= count_next;
        end
    end

    always_comb begin
        wrap          = step && (count == LAST);
        leave_visible = step && (seg == SEG_VISIBLE) && (count == VIS_LAST);
    end
endmodule

// File: rtl/status_port.sv
module status_port
    import scan_timing_pkg::*;
#(
    parameter int V_TOTAL  = 262,
    parameter int LINE_ADV = 15,
    localparam int VW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_stb,
    input  logic          hsync,
    input  logic          vsync,
    input  logic          blank,
    input  logic [VW-1:0] vcount,
    output logic [15:0]   status_data,
    output logic          status_valid
);
    localparam int SW = VW + 1;
    localparam logic [SW-1:0] ADV_C   = SW'(LINE_ADV);
    localparam logic [SW-1:0] TOTAL_C = SW'(V_TOTAL);
    localparam logic [SW-1:0] CLAMP_C = SW'(256);

    rd_state_t   state, state_next;
    logic [SW-1:0] sum, line_adj;
    logic [7:0]  low_byte;
    logic [15:0] word;

    always_comb begin
        sum      = {1'b0, vcount} + ADV_C;
        line_adj = (sum >= TOTAL_C) ? sum - TOTAL_C : sum;
        low_byte = (line_adj >= CLAMP_C) ? 8'hFF : line_adj[7:0];
        word     = {~hsync, ~vsync, 5'b11111, ~blank, low_byte};
    end

    always_comb begin
        unique case (state)
            RD_IDLE:  state_next = rd_stb ? RD_REPLY : RD_IDLE;
            RD_REPLY: state_next = rd_stb ? RD_REPLY : RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= RD_IDLE;
        else     state <= state_next;
    end

    always_ff @(posedge clk) begin
        if (rst)         status_data <= '0;
        else if (rd_stb) status_data <= word;
    end

    always_comb status_valid = (state == RD_REPLY);
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
    import scan_timing_pkg::*;
#(
    parameter int N_TARGETS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 raise,
    input  logic                 ack,
    output logic [N_TARGETS-1:0] irq
);
    irq_state_t state, state_next;

    always_comb begin
        unique case (state)
            IRQ_IDLE:   state_next = raise ? IRQ_RAISED : IRQ_IDLE;
            IRQ_RAISED: state_next = (ack && !raise) ? IRQ_IDLE : IRQ_RAISED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= IRQ_IDLE;
        else     state <= state_next;
    end

    for (genvar i = 0; i < N_TARGETS; i++) begin : g_fan
        always_comb irq[i] = (state == IRQ_RAISED);
    end
endmodule

// File: rtl/scan_timing_status.sv
module scan_timing_status
    import scan_timing_pkg::*;
#(
    parameter int H_TOTAL    = 432,
    parameter int H_ACTIVE   = 320,
    parameter int H_SYNC_OFS = 16,
    parameter int H_SYNC_LEN = 32,
    parameter int V_TOTAL    = 262,
    parameter int V_ACTIVE   = 240,
    parameter int V_SYNC_BEG = 245,
    parameter int V_SYNC_LEN = 3,
    parameter int LINE_ADV   = 15,
    localparam int HW        = $clog2(H_TOTAL),
    localparam int VW        = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_en,
    input  logic          rd_stb,
    input  logic          irq_ack,
    output logic [HW-1:0] hcount,
    output logic [VW-1:0] vcount,
    output logic          hsync,
    output logic          vsync,
    output logic          blank,
    output logic [15:0]   status_data,
    output logic          status_valid,
    output logic          vint_main,
    output logic          vint_sub
);
    localparam int H_SYNC_BEG = H_ACTIVE + H_SYNC_OFS;

    seg_t       h_seg, v_seg;
    logic       h_wrap, h_leave, v_wrap, v_leave;
    logic [1:0] irq_lines;

    raster_axis #(
        .TOTAL(H_TOTAL), .ACTIVE(H_ACTIVE),
        .SYNC_START(H_SYNC_BEG), .SYNC_LEN(H_SYNC_LEN)
    ) u_h (
        .clk(clk), .rst(rst), .step(pix_en),
        .count(hcount), .seg(h_seg), .wrap(h_wrap), .leave_visible(h_leave)
    );

    raster_axis #(
        .TOTAL(V_TOTAL), .ACTIVE(V_ACTIVE),
        .SYNC_START(V_SYNC_BEG), .SYNC_LEN(V_SYNC_LEN)
    ) u_v (
        .clk(clk), .rst(rst), .step(h_wrap),
        .count(vcount), .seg(v_seg), .wrap(v_wrap), .leave_visible(v_leave)
    );

    always_comb begin
        hsync = (h_seg == SEG_SYNC);
        vsync = (v_seg == SEG_SYNC);
        blank = (h_seg != SEG_VISIBLE) || (v_seg != SEG_VISIBLE);
    end

    status_port #(.V_TOTAL(V_TOTAL), .LINE_ADV(LINE_ADV)) u_stat (
        .clk(clk), .rst(rst), .rd_stb(rd_stb),
        .hsync(hsync), .vsync(vsync), .blank(blank), .vcount(vcount),
        .status_data(status_data), .status_valid(status_valid)
    );

    vint_ctrl #(.N_TARGETS(2)) u_irq (
        .clk(clk), .rst(rst), .raise(v_leave), .ack(irq_ack), .irq(irq_lines)
    );

    always_comb begin
        vint_main = irq_lines[0];
        vint_sub  = irq_lines[1];
    end
endmodule

// File: rtl/scan_timing_checker.sv
module scan_timing_checker #(
    parameter int HW = 9,
    parameter int VW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          pix_en,
    input logic          rd_stb,
    input logic          irq_ack,
    input logic [HW-1:0] hcount,
    input logic [VW-1:0] vcount,
    input logic          hsync,
    input logic          blank,
    input logic [15:0]   status_data,
    input logic          status_valid,
    input logic          vint_main,
    input logic          vint_sub
);
    logic raise_evt;
    always_comb raise_evt = pix_en && (hcount == HW'(431)) && (vcount == VW'(239));

    a_r2_hcount_range: assert property (@(posedge clk) disable iff (rst)
        hcount < HW'(432));
    a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> $stable(hcount) && $stable(vcount));
    a_r3_hsync_window: assert property (@(posedge clk) disable iff (rst)
        hsync |-> (hcount >= HW'(336)) && (hcount <= HW'(367)));
    a_r4_blank_in_vblank: assert property (@(posedge clk) disable iff (rst)
        (vcount >= VW'(240)) |-> blank);
    a_r7_valid_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> status_valid);
    a_r7_valid_only_after_strobe: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> !status_valid);
    a_r5_fixed_ones: assert property (@(posedge clk) disable iff (rst)
        status_valid |-> status_data[13:9] == 5'b11111);
    a_r8_both_lines_equal: assert property (@(posedge clk) disable iff (rst)
        vint_main == vint_sub);
    a_r8_rise_at_line_240: assert property (@(posedge clk) disable iff (rst)
        raise_evt |=> vint_main && (vcount == VW'(240)) && (hcount == '0));
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !raise_evt) |=> !vint_main);
endmodule

bind scan_timing_status scan_timing_checker #(.HW(HW), .VW(VW)) u_chk (
    .clk(clk), .rst(rst), .pix_en(pix_en), .rd_stb(rd_stb), .irq_ack(irq_ack),
    .hcount(hcount), .vcount(vcount), .hsync(hsync), .blank(blank),
    .status_data(status_data), .status_valid(status_valid),
    .vint_main(vint_main), .vint_sub(vint_sub)
);

// File: tb/sim_scan_timing_status.sv
module sim_scan_timing_status;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst, pix_en, rd_stb, irq_ack;
    logic [8:0]  hcount, vcount;
    logic        hsync, vsync, blank, status_valid, vint_main, vint_sub;
    logic [15:0] status_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // model state after the last rising edge
    int          m_h = 0, m_v = 0;
    bit          m_irq = 0, m_valid = 0;
    logic [15:0] m_stat = 16'h0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_timing_status u0 (
        .clk(clk), .rst(rst), .pix_en(pix_en), .rd_stb(rd_stb), .irq_ack(irq_ack),
        .hcount(hcount), .vcount(vcount), .hsync(hsync), .vsync(vsync), .blank(blank),
        .status_data(status_data), .status_valid(status_valid),
        .vint_main(vint_main), .vint_sub(vint_sub)
    );

    function automatic bit f_hs(int h); return h >= 336 && h <= 367; endfunction
    function automatic bit f_vs(int v); return v >= 245 && v <= 247; endfunction
    function automatic bit f_bl(int h, int v); return h >= 320 || v >= 240; endfunction
    function automatic logic [15:0] f_word(int h, int v);
        int l;
        logic [15:0] w;
        l = (v + 15) % 262;
        w[15]   = ~f_hs(h);
        w[14]   = ~f_vs(v);
        w[13:9] = 5'b11111;
        w[8]    = ~f_bl(h, v);
        w[7:0]  = (l >= 256) ? 8'hFF : 8'(l);
        return w;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R2 hcount", int'(hcount), m_h);
        check("R2 vcount", int'(vcount), m_v);
        check("R3 hsync", int'(hsync), int'(f_hs(m_h)));
        check("R3 vsync", int'(vsync), int'(f_vs(m_v)));
        check("R4 blank", int'(blank), int'(f_bl(m_h, m_v)));
        check("R7 status_valid", int'(status_valid), int'(m_valid));
        check("R5/R6 status_data", int'(status_data), int'(m_stat));
        check("R8/R9 vint_main", int'(vint_main), int'(m_irq));
        check("R8 vint_sub", int'(vint_sub), int'(m_irq));
    endtask

    // one cycle: compare at falling edge, drive, advance model
    task automatic cycle(bit r, bit pe, bit rd, bit ak);
        bit raise;
        @(negedge clk);
        compare_all();
        rst = r; pix_en = pe; rd_stb = rd; irq_ack = ak;
        if (r) begin
            m_h = 0; m_v = 0; m_irq = 0; m_valid = 0; m_stat = 16'h0000;
        end else begin
            raise   = pe && m_h == 431 && m_v == 239;
            m_valid = rd;
            if (rd) m_stat = f_word(m_h, m_v);
            if (raise) m_irq = 1;
            else if (ak) m_irq = 0;
            if (pe) begin
                if (m_h == 431) begin
                    m_h = 0;
                    m_v = (m_v == 261) ? 0 : m_v + 1;
                end else m_h = m_h + 1;
            end
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1; pix_en = 0; rd_stb = 0; irq_ack = 0;
        // R1: reset values
        cycle(1, 1, 1, 1);
        cycle(1, 0, 0, 0);
        @(negedge clk);
        check("R1 hcount reset", int'(hcount), 0);
        check("R1 vcount reset", int'(vcount), 0);
        check("R1 irq reset", int'(vint_main | vint_sub), 0);
        check("R1 status reset", int'({status_valid, status_data}), 0);
        // R9: acknowledge while idle has no effect; R6 read at line 0 gives 15
        cycle(0, 0, 1, 1);
        cycle(0, 0, 0, 0);
        check("R6 line 0 reads 15", int'(status_data[7:0]), 15);
        // slow pixel enable with random reads and acks
        for (int i = 0; i < 3000; i++)
            cycle(0, ($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 512) == 0);
        // dense run through a full frame, with directed set/ack collision
        for (int i = 0; i < 116000; i++) begin
            bit ak, rd;
            rd = ($urandom % 8) == 0;
            ak = ($urandom % 2048) == 0;
            if (m_h == 431 && m_v == 239) ak = 1;     // R9: raise wins over ack
            if (m_v == 240 && m_h == 40) ak = 1;      // R9: ack clears
            if (m_h == 0 && (m_v == 240 || m_v == 241 || m_v == 246 || m_v == 247)) rd = 1; // R6 edges
            if (m_h == 340 && m_v == 246) rd = 1;     // R5: both syncs active
            cycle(0, 1'b1, rd, ak);
        end
        // R1: reset in mid-frame
        cycle(1, 1, 0, 0);
        cycle(0, 0, 0, 0);
        check("R1 mid-frame reset hcount", int'(hcount), 0);
        check("R1 mid-frame reset vcount", int'(vcount), 0);
        for (int i = 0; i < 20; i++) cycle(0, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        compare_all();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule